// File: doc/BRIEF.md
# Texture Packet Buffer and Walker

This block gathers 32-bit texture packet words from a host write port into a word-wide buffer. When a flush command arrives, it does not pop the words in order. It reads the stored stream as a chain of variable-length packets. A size field in the first word of each packet gives the distance to the next packet. For each packet, the block offers three things to a downstream texture writer through a valid/ready handshake: the header word, the buffer index where the payload starts, and the packet length in words. The writer fetches payload words through a separate read port on the buffer.

Some contents are dropped instead of being walked. A flush with too few stored words uploads nothing. A packet whose computed length is zero stops the walk at once. After every flush the write index returns to zero. A write that arrives when the buffer is full is discarded and raises a sticky error flag. A once-per-frame sync pulse clears that flag. The same pulse also samples and clears a flag that records whether a flush happened during the frame.

Top module: `txq_packet_parser`

## Requirements
- R1: After reset, wr_ready is 1 and pkt_valid, busy, ovf_err and cmd_seen are all 0.
- R2: An accepted write (wr_valid and wr_ready both high) stores wr_data at the next free index, starting at 0. With REG_RD_OUT=1, rd_data shows the word at rd_addr one clock after rd_addr is applied.
- R3: When DEPTH words are already stored, an accepted write is discarded. It leaves every stored word unchanged and sets ovf_err on the next clock.
- R4: ovf_err stays set until a frame_sync pulse clears it. If an overflow happens in the same cycle as frame_sync, the flag stays set.
- R5: A flush with 2 or fewer stored words produces no packet and never raises busy. The next write lands at index 0.
- R6: For a packet at index i, pkt_len = floor((2 + floor(w0/2)) / 4), where w0 is the word at i. pkt_header is the word at i+1 and pkt_start is i+2.
- R7: The walk starts at index 0. It moves to i + pkt_len after each handshake and offers a packet only while i < (stored count - 2), with the count taken at flush time.
- R8: A computed length of zero ends the walk at once without offering that packet. Everything after it is dropped.
- R9: While pkt_valid is high and pkt_ready is low, pkt_valid stays high and pkt_header, pkt_start and pkt_len hold their values.
- R10: While busy, wr_ready is 0. Writes and flush requests are ignored, so stored words are not changed and no second walk follows.
- R11: When the walk ends, busy falls and the write index returns to 0.
- R12: An accepted flush sets a pending command flag. Each frame_sync copies the pending flag to cmd_seen and clears the pending flag. A frame_sync with no flush since the previous one gives cmd_seen = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Host write word |
| wr_ready | output | 1 | Write port ready; low while walking and in a flush cycle |
| flush | input | 1 | Flush command pulse |
| frame_sync | input | 1 | Once-per-frame pulse |
| busy | output | 1 | Walk in progress |
| ovf_err | output | 1 | Sticky overflow flag |
| cmd_seen | output | 1 | Flush-in-frame flag sampled at the last frame_sync |
| pkt_valid | output | 1 | Packet descriptor valid |
| pkt_ready | input | 1 | Downstream accepts the descriptor |
| pkt_header | output | DATA_W | Packet header word |
| pkt_start | output | CW | Buffer index of the first payload word |
| pkt_len | output | DATA_W-2 | Packet length in words |
| rd_addr | input | AW | Payload read index |
| rd_data | output | DATA_W | Payload read data |

## Verification
The bound checker watches several rules on every cycle. It checks that writes are stalled while busy and that the descriptor holds steady under backpressure. It checks that no zero-length descriptor is ever offered and that every offered start index lies within the stored count. It also checks that the overflow flag is sticky and is set by a write at full, that the fill count stays bounded, and that a short flush clears the buffer without starting a walk. Some behaviour only the directed scenarios can show. These are the exact packet boundaries computed from the size field, and truncation at a zero-length packet. They also include the proof that an ignored write left memory untouched (read back through the payload port), the index reset after each flush, and the frame-by-frame sampling of the command flag.

// File: rtl/txq_pkg.sv
package txq_pkg;
   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_FETCH = 2'd1,
      WS_OFFER = 2'd2
   } walk_state_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 1024,
   parameter bit REG_RD_OUT = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr_fill,
   output logic [CW-1:0]     fill_cnt,
   output logic              ovf_pulse,
   input  logic [AW-1:0]     walk_a_addr,
   output logic [DATA_W-1:0] walk_a_data,
   input  logic [AW-1:0]     walk_b_addr,
   output logic [DATA_W-1:0] walk_b_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic              full;
   logic              store_en;

   assign full      = (fill_cnt == CW'(DEPTH));
   assign store_en  = wr_en && !full && !clr_fill;
   assign ovf_pulse = wr_en && full && !clr_fill;

   always_ff @(posedge clk) begin
      if (store_en) mem[fill_cnt[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        fill_cnt <= '0;
      else if (clr_fill) fill_cnt <= '0;
      else if (store_en) fill_cnt <= fill_cnt + CW'(1);
   end

   assign walk_a_data = mem[walk_a_addr];
   assign walk_b_data = mem[walk_b_addr];

   generate
      if (REG_RD_OUT) begin : g_rd_reg
         always_ff @(posedge clk) rd_data <= mem[rd_addr];
      end else begin : g_rd_comb
         assign rd_data = mem[rd_addr];
      end
   endgenerate
endmodule

// File: rtl/txq_walker.sv
module txq_walker
   import txq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 1024,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int LEN_W = DATA_W - 2,
   localparam int IW    = DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [CW-1:0]     fill_cnt,
   output logic [AW-1:0]     size_addr,
   input  logic [DATA_W-1:0] size_word,
   output logic [AW-1:0]     hdr_addr,
   input  logic [DATA_W-1:0] hdr_word,
   output logic              clr_fill,
   output logic              flush_acc,
   output logic              busy,
   output logic              pkt_valid,
   input  logic              pkt_ready,
   output logic [DATA_W-1:0] pkt_header,
   output logic [CW-1:0]     pkt_start,
   output logic [LEN_W-1:0]  pkt_len
);
   walk_state_t      st;
   logic [IW-1:0]    idx;
   logic [CW-1:0]    lim;
   logic [DATA_W:0]  len_sum;
   logic [LEN_W-1:0] cur_len;
   logic             at_end;
   logic             short_fill;

   // length in words = (2 + w0/2) / 4, integer division
   assign len_sum    = {2'b00, size_word[DATA_W-1:1]} + (DATA_W+1)'(2);
   assign cur_len    = len_sum[LEN_W+1:2];
   assign at_end     = (idx >= {{(IW-CW){1'b0}}, lim}) || (cur_len == '0);
   assign short_fill = (fill_cnt <= CW'(2));

   assign size_addr  = idx[AW-1:0];
   assign hdr_addr   = idx[AW-1:0] + AW'(1);

   assign flush_acc  = (st == WS_IDLE) && flush;
   assign clr_fill   = (flush_acc && short_fill) || ((st == WS_FETCH) && at_end);
   assign busy       = (st != WS_IDLE);
   assign pkt_valid  = (st == WS_OFFER);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= WS_IDLE;
         idx        <= '0;
         lim        <= '0;
         pkt_header <= '0;
         pkt_start  <= '0;
         pkt_len    <= '0;
      end else begin
         case (st)
            WS_IDLE: begin
               if (flush && !short_fill) begin
                  lim <= fill_cnt - CW'(2);
                  idx <= '0;
                  st  <= WS_FETCH;
               end
            end
            WS_FETCH: begin
               if (at_end) begin
                  st <= WS_IDLE;
               end else begin
                  pkt_header <= hdr_word;
                  pkt_start  <= idx[CW-1:0] + CW'(2);
                  pkt_len    <= cur_len;
                  st         <= WS_OFFER;
               end
            end
            WS_OFFER: begin
               if (pkt_ready) begin
                  idx <= idx + {{(IW-LEN_W){1'b0}}, pkt_len};
                  st  <= WS_FETCH;
               end
            end
            default: st <= WS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/txq_frame_flags.sv
module txq_frame_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_sync,
   input  logic ovf_pulse,
   input  logic flush_acc,
   output logic ovf_err,
   output logic cmd_seen
);
   logic cmd_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_err  <= 1'b0;
         cmd_pend <= 1'b0;
         cmd_seen <= 1'b0;
      end else begin
         if (ovf_pulse)       ovf_err <= 1'b1;
         else if (frame_sync) ovf_err <= 1'b0;

         if (frame_sync) begin
            cmd_seen <= cmd_pend;
            cmd_pend <= flush_acc;
         end else if (flush_acc) begin
            cmd_pend <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/txq_packet_parser.sv
module txq_packet_parser #(
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 1024,
   parameter bit REG_RD_OUT = 1'b1,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int LEN_W = DATA_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              flush,
   input  logic              frame_sync,
   output logic              busy,
   output logic              ovf_err,
   output logic              cmd_seen,
   output logic              pkt_valid,
   input  logic              pkt_ready,
   output logic [DATA_W-1:0] pkt_header,
   output logic [CW-1:0]     pkt_start,
   output logic [LEN_W-1:0]  pkt_len,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("txq_packet_parser: DEPTH must be at least 4");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("txq_packet_parser: DATA_W must be at least 8");
      end
      if (CW > DATA_W) begin : g_bad_ratio
         $error("txq_packet_parser: DEPTH too large for DATA_W");
      end
   endgenerate

   logic [CW-1:0]     fill_cnt;
   logic              ovf_pulse;
   logic              clr_fill;
   logic              flush_acc;
   logic              wr_en;
   logic [AW-1:0]     size_addr;
   logic [AW-1:0]     hdr_addr;
   logic [DATA_W-1:0] size_word;
   logic [DATA_W-1:0] hdr_word;

   assign wr_ready = !busy && !flush;
   assign wr_en    = wr_valid && wr_ready;

   txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .REG_RD_OUT(REG_RD_OUT)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .clr_fill    (clr_fill),
      .fill_cnt    (fill_cnt),
      .ovf_pulse   (ovf_pulse),
      .walk_a_addr (size_addr),
      .walk_a_data (size_word),
      .walk_b_addr (hdr_addr),
      .walk_b_data (hdr_word),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data)
   );

   txq_walker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .fill_cnt   (fill_cnt),
      .size_addr  (size_addr),
      .size_word  (size_word),
      .hdr_addr   (hdr_addr),
      .hdr_word   (hdr_word),
      .clr_fill   (clr_fill),
      .flush_acc  (flush_acc),
      .busy       (busy),
      .pkt_valid  (pkt_valid),
      .pkt_ready  (pkt_ready),
      .pkt_header (pkt_header),
      .pkt_start  (pkt_start),
      .pkt_len    (pkt_len)
   );

   txq_frame_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_sync (frame_sync),
      .ovf_pulse  (ovf_pulse),
      .flush_acc  (flush_acc),
      .ovf_err    (ovf_err),
      .cmd_seen   (cmd_seen)
   );
endmodule

// File: rtl/txq_packet_parser_chk.sv
module txq_packet_parser_chk #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 1024,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int LEN_W = DATA_W - 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic              flush,
   input logic              frame_sync,
   input logic              busy,
   input logic              ovf_err,
   input logic              pkt_valid,
   input logic              pkt_ready,
   input logic [DATA_W-1:0] pkt_header,
   input logic [CW-1:0]     pkt_start,
   input logic [LEN_W-1:0]  pkt_len,
   input logic [CW-1:0]     fill_cnt
);
   p_ready_low_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wr_ready);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_header)
                                     && $stable(pkt_start) && $stable(pkt_len)));

   p_len_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (pkt_len != '0));

   p_start_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |-> (pkt_start <= fill_cnt));

   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_err && !frame_sync) |=> ovf_err);

   p_ovf_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && (fill_cnt == CW'(DEPTH))) |=> ovf_err);

   p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fill_cnt <= CW'(DEPTH));

   p_short_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && flush && (fill_cnt <= CW'(2))) |=> (!busy && (fill_cnt == '0)));
endmodule

bind txq_packet_parser txq_packet_parser_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .flush      (flush),
   .frame_sync (frame_sync),
   .busy       (busy),
   .ovf_err    (ovf_err),
   .pkt_valid  (pkt_valid),
   .pkt_ready  (pkt_ready),
   .pkt_header (pkt_header),
   .pkt_start  (pkt_start),
   .pkt_len    (pkt_len),
   .fill_cnt   (fill_cnt)
);

// File: tb/txq_packet_parser_tb_top.sv
`timescale 1ns/1ps
module txq_packet_parser_tb_top;
   localparam int DW  = 32;
   localparam int DEP = 16;
   localparam int AW  = $clog2(DEP);
   localparam int CW  = $clog2(DEP + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_ready;
   logic          flush = 1'b0;
   logic          frame_sync = 1'b0;
   logic          busy, ovf_err, cmd_seen, pkt_valid;
   logic          pkt_ready = 1'b0;
   logic [DW-1:0] pkt_header;
   logic [CW-1:0] pkt_start;
   logic [DW-3:0] pkt_len;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   txq_packet_parser #(.DATA_W(DW), .DEPTH(DEP), .REG_RD_OUT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .flush(flush), .frame_sync(frame_sync), .busy(busy),
      .ovf_err(ovf_err), .cmd_seen(cmd_seen), .pkt_valid(pkt_valid),
      .pkt_ready(pkt_ready), .pkt_header(pkt_header), .pkt_start(pkt_start),
      .pkt_len(pkt_len), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_word(logic [DW-1:0] d);
      wr_valid = 1'b1; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic pulse_flush();
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic pulse_frame();
      frame_sync = 1'b1;
      @(negedge clk);
      frame_sync = 1'b0;
   endtask

   task automatic read_mem(logic [AW-1:0] a, output logic [DW-1:0] v);
      rd_addr = a;
      @(negedge clk);
      v = rd_data;
   endtask

   task automatic wait_pkt(string req);
      for (int i = 0; i < 20 && !pkt_valid; i++) @(negedge clk);
      check({req, " pkt_valid"}, {31'b0, pkt_valid}, 32'd1);
   endtask

   task automatic take_pkt(string req, logic [DW-1:0] h, int s, int l);
      wait_pkt(req);
      check({req, " header"}, pkt_header, h);
      check({req, " start"}, {{(DW-CW){1'b0}}, pkt_start}, DW'(s));
      check({req, " len"}, {2'b00, pkt_len}, DW'(l));
      pkt_ready = 1'b1;
      @(negedge clk);
      pkt_ready = 1'b0;
   endtask

   task automatic expect_quiet(string req, int n);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         if (pkt_valid) seen++;
         @(negedge clk);
      end
      check({req, " no packet"}, DW'(seen), 32'd0);
      check({req, " idle"}, {31'b0, busy}, 32'd0);
   endtask

   task automatic load_walk_stream();
      write_word(32'd24); write_word(32'h1111_0001); write_word(32'hCAFE_0000);
      write_word(32'd14); write_word(32'h2222_0002); write_word(32'd8);
      write_word(32'h3333_0003); write_word(32'hDEAD_0007);
   endtask

   task automatic t_reset();
      check("R1 wr_ready", {31'b0, wr_ready}, 32'd1);
      check("R1 pkt_valid", {31'b0, pkt_valid}, 32'd0);
      check("R1 busy", {31'b0, busy}, 32'd0);
      check("R1 ovf_err", {31'b0, ovf_err}, 32'd0);
      check("R1 cmd_seen", {31'b0, cmd_seen}, 32'd0);
   endtask

   task automatic t_walk();
      logic [DW-1:0] v;
      load_walk_stream();
      read_mem(4'd2, v);
      check("R2 stored word", v, 32'hCAFE_0000);
      pulse_flush();
      take_pkt("R6 first", 32'h1111_0001, 2, 3);
      take_pkt("R7 second", 32'h2222_0002, 5, 2);
      take_pkt("R7 third", 32'h3333_0003, 7, 1);
      expect_quiet("R7 end", 6);
      write_word(32'h0000_A0A0);
      read_mem(4'd0, v);
      check("R11 index reset", v, 32'h0000_A0A0);
      pulse_flush();
   endtask

   task automatic t_zero_len();
      logic [DW-1:0] v;
      write_word(32'd24); write_word(32'hAAAA_0001); write_word(32'h0B0B_0002);
      write_word(32'd1);  write_word(32'hBBBB_0004); write_word(32'h0B0B_0005);
      write_word(32'd8);  write_word(32'hCCCC_0007); write_word(32'h5A5A_0008);
      pulse_flush();
      take_pkt("R8 before stop", 32'hAAAA_0001, 2, 3);
      expect_quiet("R8 truncated", 8);
      write_word(32'h0000_0077);
      read_mem(4'd0, v);
      check("R8 dropped rest", v, 32'h0000_0077);
      pulse_flush();
   endtask

   task automatic t_short();
      logic [DW-1:0] v;
      write_word(32'h0000_0010);
      write_word(32'h0000_0020);
      pulse_flush();
      check("R5 no busy", {31'b0, busy}, 32'd0);
      expect_quiet("R5 short flush", 6);
      write_word(32'h0000_00C3);
      read_mem(4'd0, v);
      check("R5 index reset", v, 32'h0000_00C3);
      pulse_flush();
   endtask

   task automatic t_stall();
      logic [DW-1:0] v;
      logic [DW-1:0] h0;
      logic [CW-1:0] s0;
      load_walk_stream();
      pulse_flush();
      wait_pkt("R9 first");
      h0 = pkt_header; s0 = pkt_start;
      check("R10 stalled", {31'b0, wr_ready}, 32'd0);
      wr_valid = 1'b1; wr_data = 32'h0BAD_0BAD; flush = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0; flush = 1'b0;
      for (int i = 0; i < 3; i++) @(negedge clk);
      check("R9 still valid", {31'b0, pkt_valid}, 32'd1);
      check("R9 header held", pkt_header, h0);
      check("R9 start held", {{(DW-CW){1'b0}}, pkt_start}, {{(DW-CW){1'b0}}, s0});
      check("R9 len held", {2'b00, pkt_len}, 32'd3);
      read_mem(4'd8, v);
      check("R10 write ignored", v, 32'h5A5A_0008);
      pkt_ready = 1'b1;
      @(negedge clk);
      pkt_ready = 1'b0;
      take_pkt("R9 second", 32'h2222_0002, 5, 2);
      take_pkt("R9 third", 32'h3333_0003, 7, 1);
      expect_quiet("R10 flush ignored", 10);
      write_word(32'h0000_00E1);
      read_mem(4'd0, v);
      check("R11 after stall", v, 32'h0000_00E1);
      pulse_flush();
   endtask

   task automatic t_overflow();
      logic [DW-1:0] v;
      write_word(32'd1);
      for (int i = 1; i < DEP; i++) write_word(32'h0D00_0000 + DW'(i));
      check("R3 no error at full", {31'b0, ovf_err}, 32'd0);
      write_word(32'hFFFF_0000);
      check("R3 error set", {31'b0, ovf_err}, 32'd1);
      read_mem(4'd15, v);
      check("R3 last word kept", v, 32'h0D00_000F);
      for (int i = 0; i < 3; i++) @(negedge clk);
      check("R4 sticky", {31'b0, ovf_err}, 32'd1);
      pulse_frame();
      check("R4 cleared", {31'b0, ovf_err}, 32'd0);
      pulse_flush();
      expect_quiet("R8 leading zero length", 6);
      write_word(32'h0000_00D1);
      read_mem(4'd0, v);
      check("R11 after overflow", v, 32'h0000_00D1);
      pulse_flush();
   endtask

   task automatic t_cmd_flag();
      pulse_frame();
      check("R12 flush seen", {31'b0, cmd_seen}, 32'd1);
      pulse_frame();
      check("R12 quiet frame", {31'b0, cmd_seen}, 32'd0);
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_walk();
      t_zero_len();
      t_short();
      t_stall();
      t_overflow();
      t_cmd_flag();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule